// File: doc/BRIEF.md
# FIFO with serially loaded flag offsets

This block is a 9-bit wide first-in first-out buffer whose depth is set by a parameter between 256 and 8192 words. It reports four active-low status flags: full, empty, almost-full and almost-empty. The two "almost" thresholds are programmable. They are not mapped at addresses. They are reached through the ordinary data ports.

When the load input is low, a write-enabled cycle stores the data input into one of four threshold registers. A read-enabled cycle returns one of them on the data output. Each side keeps a two-bit sequence pointer that steps through the registers in a fixed rotation and wraps after four accesses. When the load input is high, the same enables move words into and out of the buffer.

The write and read sides have their own clock inputs. Occupancy is formed directly from the two binary pointers, with no synchronizers, so the clocks must be the same clock or driven from a common source. A register access on each side in the same cycle is not allowed, and users must avoid it.

Top module: `sfifo_offs`

## Requirements
- R1: Asynchronous reset (rst_n low) clears both buffer pointers and both sequence pointers. After reset, empty_n=0, full_n=1, aempty_n=0 and afull_n=1. Both threshold values are 7: low byte 7, upper part 0.
- R2: With ld=0 and wen_n=0, each rising wclk edge stores din into the next threshold register and advances the write sequence pointer. The rotation is: empty low byte, empty upper part, full low byte, full upper part, then back to empty low byte.
- R3: With ld=0 and ren_n=0, each rising rclk edge loads dout with the next threshold register in the same rotation, using a separate read sequence pointer. A low byte reads back as {1'b0, byte}. An upper part stores only din[AW-9:0], where AW=log2(DEPTH), and reads back zero-extended. The buffer read pointer does not move.
- R4: With wen_n=1, nothing is written for either value of ld. Both the buffer contents and the thresholds stay unchanged.
- R5: With ld=1 and wen_n=0, din is stored in the buffer. With ld=1 and ren_n=0, the oldest word appears on dout after that rclk edge. Words come out in the order they were written.
- R6: With no reads after reset, full_n goes low on the edge of the DEPTH-th write. While full_n is low, buffer writes are dropped. full_n returns high on the wclk edge after a read has freed a location.
- R7: empty_n goes low on the rclk edge that reads the last stored word. It goes high on the rclk edge that follows a write. While empty_n is low, buffer reads are dropped and dout holds its value.
- R8: aempty_n is low while the stored word count is at or below the empty threshold. It follows a read on that same rclk edge, and a write on the next rclk edge.
- R9: afull_n is low while the free space (DEPTH minus count) is at or below the full threshold. It follows a write on that same wclk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | 1 selects the buffer, 0 selects the threshold registers |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| din | input | 9 | Write data, buffer word or threshold value |
| dout | output | 9 | Registered read data |
| full_n | output | 1 | Low when the buffer is full |
| empty_n | output | 1 | Low when the buffer is empty |
| afull_n | output | 1 | Low when free space is at or below the full threshold |
| aempty_n | output | 1 | Low when the count is at or below the empty threshold |

## Verification
The bench targets the following corner cases:

- **Wrap of the sequence pointer.** Eight threshold writes and eight readbacks are checked. A pointer that saturated or restarted at the wrong register would return a shifted value.
- **Upper-part masking.** A 9-bit pattern is written into an upper part. A design that kept all of din would read back 0x1FF or 0x1FE instead of 0x001 or 0x000.
- **Exact edges of the flags.** Both sides of the threshold crossings are checked: full after exactly DEPTH writes, and empty on the last read. An off-by-one comparison would move a flag edge by one word.
- **Dropped accesses.** A write into a full buffer, a read from an empty one, and strobes with the enable inactive are all checked. A design that let any of these through would show a stray word in the read-out or a changed threshold.

// File: rtl/sfifo_offs.sv
module sfifo_offs #(
  parameter int DEPTH = 512
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       wen_n,
  input  logic       ren_n,
  input  logic [8:0] din,
  output logic [8:0] dout,
  output logic       full_n,
  output logic       empty_n,
  output logic       afull_n,
  output logic       aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = (AW > 8) ? AW - 8 : 1;
  localparam logic [AW:0] DCNT = (AW+1)'(DEPTH);

  logic [8:0]    mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic [1:0]    wsel, rsel;
  logic [7:0]    elo, flo;
  logic [HW-1:0] ehi, fhi;
  logic [AW:0]   eoff, foff;
  logic [8:0]    cfg_q;

  generate
    if (AW > 8) begin : g_hi
      assign eoff = {1'b0, ehi, elo};
      assign foff = {1'b0, fhi, flo};
    end else begin : g_lo
      assign eoff = {1'b0, elo};
      assign foff = {1'b0, flo};
    end
  endgenerate

  wire          wr_fifo = ld & ~wen_n & full_n;
  wire          wr_cfg  = ~ld & ~wen_n;
  wire [AW:0]   wnext   = wptr + {{AW{1'b0}}, wr_fifo};
  wire [AW:0]   wcnt    = wnext - rptr;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      wsel    <= '0;
      elo     <= 8'd7;
      flo     <= 8'd7;
      ehi     <= '0;
      fhi     <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wptr    <= wnext;
      full_n  <= (wcnt != DCNT);
      afull_n <= ((DCNT - wcnt) > foff);
      if (wr_cfg) begin
        wsel <= wsel + 2'd1;
        case (wsel)
          2'd0: elo <= din[7:0];
          2'd1: ehi <= (AW > 8) ? din[HW-1:0] : '0;
          2'd2: flo <= din[7:0];
          default: fhi <= (AW > 8) ? din[HW-1:0] : '0;
        endcase
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fifo) mem[wptr[AW-1:0]] <= din;
  end

  always_comb begin
    case (rsel)
      2'd0: cfg_q = {1'b0, elo};
      2'd1: cfg_q = 9'(ehi);
      2'd2: cfg_q = {1'b0, flo};
      default: cfg_q = 9'(fhi);
    endcase
  end

  wire        rd_fifo = ld & ~ren_n & empty_n;
  wire        rd_cfg  = ~ld & ~ren_n;
  wire [AW:0] rnext   = rptr + {{AW{1'b0}}, rd_fifo};
  wire [AW:0] rcnt    = wptr - rnext;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rsel     <= '0;
      dout     <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rptr     <= rnext;
      empty_n  <= (rcnt != '0);
      aempty_n <= (rcnt > eoff);
      if (rd_fifo) begin
        dout <= mem[rptr[AW-1:0]];
      end else if (rd_cfg) begin
        dout <= cfg_q;
        rsel <= rsel + 2'd1;
      end
    end
  end
endmodule

// File: rtl/sfifo_offs_chk.sv
module sfifo_offs_chk #(
  parameter int DEPTH = 512,
  parameter int CW = 18
) (
  input logic                       wclk,
  input logic                       rclk,
  input logic                       rst_n,
  input logic                       ld,
  input logic                       wen_n,
  input logic                       ren_n,
  input logic                       full_n,
  input logic                       empty_n,
  input logic [8:0]                 dout,
  input logic [$clog2(DEPTH):0]     wptr,
  input logic [$clog2(DEPTH):0]     rptr,
  input logic [CW-1:0]              cfg
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DCNT = (AW+1)'(DEPTH);

  logic [AW:0] cnt;
  assign cnt = wptr - rptr;

  p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    cnt <= DCNT);
  p_full_flag_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    full_n |-> (cnt != DCNT));
  p_full_blocks_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && ld && !wen_n) |=> $stable(wptr));
  p_empty_flag_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_n |-> (cnt != '0));
  p_empty_blocks_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && ld && !ren_n) |=> $stable(dout));
  p_idle_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    wen_n |=> ($stable(wptr) && $stable(cfg)));
  p_cfg_read_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ld && !ren_n) |=> $stable(rptr));
endmodule

bind sfifo_offs sfifo_offs_chk #(.DEPTH(DEPTH), .CW(16 + 2*HW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld(ld), .wen_n(wen_n), .ren_n(ren_n),
  .full_n(full_n), .empty_n(empty_n), .dout(dout), .wptr(wptr), .rptr(rptr),
  .cfg({elo, ehi, flo, fhi})
);

// File: tb/sfifo_offs_tb.sv
module sfifo_offs_tb;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic full_n, empty_n, afull_n, aempty_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sfifo_offs #(.DEPTH(DEPTH)) u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld(ld), .wen_n(wen_n), .ren_n(ren_n),
    .din(din), .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .afull_n(afull_n), .aempty_n(aempty_n)
  );

  // {is_read, din, expected dout}
  localparam logic [18:0] VEC [16] = '{
    {1'b0, 9'h005, 9'h000}, {1'b0, 9'h1FF, 9'h000}, {1'b0, 9'h00A, 9'h000}, {1'b0, 9'h1FE, 9'h000},
    {1'b1, 9'h000, 9'h005}, {1'b1, 9'h000, 9'h001}, {1'b1, 9'h000, 9'h00A}, {1'b1, 9'h000, 9'h000},
    {1'b0, 9'h003, 9'h000}, {1'b0, 9'h000, 9'h000}, {1'b0, 9'h004, 9'h000}, {1'b0, 9'h000, 9'h000},
    {1'b1, 9'h000, 9'h003}, {1'b1, 9'h000, 9'h000}, {1'b1, 9'h000, 9'h004}, {1'b1, 9'h000, 9'h000}
  };

  function automatic logic [8:0] data(input int i);
    return 9'((i * 37 + 11) % 512);
  endfunction

  task automatic step(input logic l, input logic w, input logic r, input logic [8:0] d);
    ld = l; wen_n = w; ren_n = r; din = d;
    @(posedge clk);
    #2;
    ld = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R1 empty_n", 9'(empty_n), 9'd0);
    check("R1 full_n", 9'(full_n), 9'd1);
    check("R1 aempty_n", 9'(aempty_n), 9'd0);
    check("R1 afull_n", 9'(afull_n), 9'd1);
    step(1'b0, 1'b1, 1'b0, '0); check("R1 empty lo", dout, 9'h007);
    step(1'b0, 1'b1, 1'b0, '0); check("R1 empty hi", dout, 9'h000);
    step(1'b0, 1'b1, 1'b0, '0); check("R1 full lo", dout, 9'h007);
    step(1'b0, 1'b1, 1'b0, '0); check("R1 full hi", dout, 9'h000);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][18]) begin
        step(1'b0, 1'b1, 1'b0, '0);
        check("R2 R3 sequence", dout, VEC[i][8:0]);
      end else begin
        step(1'b0, 1'b0, 1'b1, VEC[i][17:9]);
      end
    end

    // empty threshold 3, full threshold 4
    step(1'b1, 1'b1, 1'b0, '0);
    check("R7 read while empty", dout, 9'h000);

    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 1'b1, data(i));
      if (i == 0) check("R7 empty lag", 9'(empty_n), 9'd0);
      if (i == 1) check("R7 empty clear", 9'(empty_n), 9'd1);
      if (i == 3) check("R8 count 3", 9'(aempty_n), 9'd0);
      if (i == 4) check("R8 count 4", 9'(aempty_n), 9'd1);
      if (i == DEPTH-6) check("R9 free 5", 9'(afull_n), 9'd1);
      if (i == DEPTH-5) check("R9 free 4", 9'(afull_n), 9'd0);
      if (i == DEPTH-2) check("R6 one left", 9'(full_n), 9'd1);
      if (i == DEPTH-1) check("R6 full", 9'(full_n), 9'd0);
    end
    step(1'b1, 1'b0, 1'b1, 9'h0AA);
    check("R6 stays full", 9'(full_n), 9'd0);

    for (int j = 0; j < DEPTH; j++) begin
      step(1'b1, 1'b1, 1'b0, '0);
      check("R5 order", dout, data(j));
      if (j == 1) check("R6 full release", 9'(full_n), 9'd1);
      if (j == DEPTH-5) check("R8 count 4 on read", 9'(aempty_n), 9'd1);
      if (j == DEPTH-4) check("R8 count 3 on read", 9'(aempty_n), 9'd0);
      if (j == DEPTH-2) check("R7 one left", 9'(empty_n), 9'd1);
      if (j == DEPTH-1) check("R7 empty", 9'(empty_n), 9'd0);
    end
    step(1'b1, 1'b1, 1'b0, '0);
    check("R7 dout holds", dout, data(DEPTH-1));

    step(1'b1, 1'b1, 1'b1, 9'h155);
    step(1'b0, 1'b1, 1'b1, 9'h0FF);
    step(1'b1, 1'b1, 1'b1, '0);
    step(1'b1, 1'b1, 1'b1, '0);
    check("R4 no word", 9'(empty_n), 9'd0);
    step(1'b0, 1'b1, 1'b0, '0); check("R4 empty lo", dout, 9'h003);
    step(1'b0, 1'b1, 1'b0, '0); check("R4 empty hi", dout, 9'h000);
    step(1'b0, 1'b1, 1'b0, '0); check("R4 full lo", dout, 9'h004);
    step(1'b0, 1'b1, 1'b0, '0); check("R4 full hi", dout, 9'h000);

    step(1'b0, 1'b0, 1'b1, 9'h011);
    step(1'b1, 1'b0, 1'b1, 9'h022);
    rst_n = 1'b0;
    #3 rst_n = 1'b1;
    check_reset_state();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule